// File: doc/BRIEF.md
# Teletext Bit Request Sequencer

This block paces the serial capture of one teletext line for insertion into a video line. It runs on the 27 MHz system clock. It produces an average teletext bit rate of 6.9375 Mbit/s by mixing 3-clock and 4-clock bit periods in a fixed pattern. The pattern repeats every 37 bits, which is exactly 144 clocks.

A one-clock horizontal sync pulse starts each line. On that pulse the block latches four settings:

- the enable bit,
- the 4-bit source delay,
- the request rise position,
- the request fall position.

It then counts clocks from the sync edge. The request strobe to the data source is raised and dropped at the programmed positions. The first bit period starts a fixed 275 clocks after sync, less an internal processing latency, plus the source delay. Bits are then sampled one per period until 360 have been taken. At that point the window closes and stays closed until the next sync.

Top module: `ttx_bit_seq`

## Requirements
- R1: After reset and before the first sync pulse, `req_o`, `win_o`, `smp_o` and `bit_o` are 0 and `idx_o` is 0.
- R2: Bit periods are 4 clocks long, except bits whose 1-based position within their group of 37 is 10, 19, 28 or 37, which are 3 clocks long. `smp_o` is high for exactly one clock: the second clock of every bit period.
- R3: Let cycle 0 be the clock after the edge at which `hsync_i` is sampled high. `win_o` first rises in cycle `SYNC_TO_DATA - PROC_LAT + dly` (267 + dly with the defaults), where dly is the latched source delay.
- R4: `idx_o` is the 0-based index of the current bit. It is 0 from sync until the window opens, and it increments by one at each bit boundary.
- R5: `bit_o` holds the value of `ttx_i` sampled at the clock edge that ends the most recent `smp_o` cycle.
- R6: After bit 359 ends (1402 clocks after the window opens), `win_o`, `req_o` and `smp_o` stay low and `idx_o` stays 359 until the next sync pulse.
- R7: If `ttx_en_i` is 0 when sync is sampled, that line shows no request, no window and no sample strobe.
- R8: While a line is active and not finished, `req_o` is high exactly in the cycles whose position p satisfies rise ≤ p < fall. The position counter saturates at 2^POS_W−1.
- R9: A sync pulse during a line aborts that line, and the sequence restarts from bit 0 with newly latched settings.
- R10: The delay, rise and fall inputs are latched only at sync. Changing them mid-line has no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz system clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_i | input | 1 | One-clock pulse at the horizontal sync leading edge |
| ttx_en_i | input | 1 | Teletext enable, latched at sync |
| dly_i | input | 4 | Request-to-data source delay in clocks, latched at sync |
| req_rise_i | input | POS_W | Clock position where the request rises |
| req_fall_i | input | POS_W | Clock position where the request falls |
| ttx_i | input | 1 | Serial teletext data from the source |
| req_o | output | 1 | Data request strobe to the source |
| smp_o | output | 1 | One-clock bit sample strobe |
| bit_o | output | 1 | Most recently captured bit |
| idx_o | output | IDX_W | Index of the current bit |
| win_o | output | 1 | Insertion window active |

## Verification
The request, window, strobe and index outputs depend only on registered state. They therefore show the effect of a sync pulse in the first cycle after the edge that samples it. `bit_o` changes at the edge that closes a strobe cycle. The bench captures the inputs at each rising edge and advances its own cycle-by-cycle model by that edge. It then compares all five outputs at the following falling edge. As a result, each expected value is due exactly one edge after the stimulus that causes it.

// File: rtl/ttx_bit_seq.sv
module ttx_bit_seq #(
  parameter int POS_W        = 10,
  parameter int DLY_W        = 4,
  parameter int IDX_W        = 9,
  parameter int SYNC_TO_DATA = 275,
  parameter int PROC_LAT     = 8,
  parameter int LINE_BITS    = 360,
  parameter int GRP_BITS     = 37
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hsync_i,
  input  logic             ttx_en_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic [POS_W-1:0] req_rise_i,
  input  logic [POS_W-1:0] req_fall_i,
  input  logic             ttx_i,
  output logic             req_o,
  output logic             smp_o,
  output logic             bit_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             win_o
);
  localparam int BASE = SYNC_TO_DATA - PROC_LAT;

  logic             run, line_en, done, bit_q;
  logic [POS_W-1:0] pos, rise_q, fall_q, start;
  logic [DLY_W-1:0] dly_q;
  logic [IDX_W-1:0] idx;
  logic [5:0]       grp;
  logic [1:0]       ph, last_ph;
  logic             short_bit;

  assign start     = POS_W'(BASE) + POS_W'(dly_q);
  assign short_bit = (grp == 6'd9) || (grp == 6'd18) || (grp == 6'd27) || (grp == 6'd36);
  assign last_ph   = short_bit ? 2'd2 : 2'd3;
  assign win_o     = run && line_en && !done && (pos >= start);
  assign smp_o     = win_o && (ph == 2'd1);
  assign req_o     = run && line_en && !done && (pos >= rise_q) && (pos < fall_q);
  assign idx_o     = idx;
  assign bit_o     = bit_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run <= 1'b0; line_en <= 1'b0; done <= 1'b0; bit_q <= 1'b0;
      pos <= '0; rise_q <= '0; fall_q <= '0; dly_q <= '0;
      idx <= '0; grp <= '0; ph <= '0;
    end else if (hsync_i) begin
      run <= 1'b1; line_en <= ttx_en_i; done <= 1'b0;
      pos <= '0; rise_q <= req_rise_i; fall_q <= req_fall_i; dly_q <= dly_i;
      idx <= '0; grp <= '0; ph <= '0;
    end else begin
      if (run && pos != '1) pos <= pos + POS_W'(1);
      if (win_o) begin
        if (smp_o) bit_q <= ttx_i;
        if (ph == last_ph) begin
          ph <= '0;
          if (idx == IDX_W'(LINE_BITS-1)) done <= 1'b1;
          else begin
            idx <= idx + IDX_W'(1);
            grp <= (grp == 6'(GRP_BITS-1)) ? 6'd0 : grp + 6'd1;
          end
        end else ph <= ph + 2'd1;
      end
    end
  end

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    idx_o < IDX_W'(LINE_BITS)); // R4
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(win_o) && !$past(hsync_i) |-> (idx_o == $past(idx_o)) || (idx_o == $past(idx_o) + IDX_W'(1))); // R4
  AST_NO_DOUBLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    smp_o && !hsync_i |=> !smp_o); // R2
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hsync_i && !ttx_en_i |=> !req_o && !win_o); // R7
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    done && !hsync_i |=> !win_o && !req_o && !smp_o); // R6
  AST_WIN_OPEN_POS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_o) && !$past(hsync_i) |-> idx_o == '0); // R3
endmodule

// File: tb/ttx_bit_seq_test.sv
module ttx_bit_seq_test;
  localparam int CLK_PERIOD = 36;
  localparam int BASE = 267;
  localparam int NBITS = 360;
  localparam int WD_LIMIT = 60000;

  logic clk = 0, rst_n = 0, hsync_i = 0, ttx_en_i = 0, ttx_i = 0;
  logic [3:0] dly_i = 0;
  logic [9:0] req_rise_i = 0, req_fall_i = 0;
  logic req_o, smp_o, bit_o, win_o;
  logic [8:0] idx_o;

  ttx_bit_seq uut (.clk(clk), .rst_n(rst_n), .hsync_i(hsync_i), .ttx_en_i(ttx_en_i),
    .dly_i(dly_i), .req_rise_i(req_rise_i), .req_fall_i(req_fall_i), .ttx_i(ttx_i),
    .req_o(req_o), .smp_o(smp_o), .bit_o(bit_o), .idx_o(idx_o), .win_o(win_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;
  string phase = "R1";

  logic p_rst, p_hs, p_en, p_ttx;
  logic [3:0] p_dly;
  logic [9:0] p_rise, p_fall;
  always @(posedge clk) begin
    p_rst <= rst_n; p_hs <= hsync_i; p_en <= ttx_en_i; p_ttx <= ttx_i;
    p_dly <= dly_i; p_rise <= req_rise_i; p_fall <= req_fall_i;
  end

  bit m_run = 0, m_en = 0, m_bit = 0;
  int m_t = 0, m_ts = 0, m_dly = 0, m_rise = 0, m_fall = 0;
  bit e_req, e_win, e_smp;
  int e_idx;

  function automatic int blen(int k);
    int g = k % 37;
    return (g == 9 || g == 18 || g == 27 || g == 36) ? 3 : 4;
  endfunction

  task automatic evaluate();
    int rel, k, acc;
    bit fin;
    e_req = 0; e_win = 0; e_smp = 0; e_idx = 0; fin = 0;
    if (m_run && m_en) begin
      rel = m_t - (BASE + m_dly);
      k = 0; acc = 0;
      if (rel >= 0) begin
        while (k < NBITS && acc + blen(k) <= rel) begin acc += blen(k); k++; end
        if (k >= NBITS) begin fin = 1; e_idx = NBITS - 1; end
        else begin e_idx = k; e_win = 1; e_smp = (rel - acc == 1); end
      end
      e_req = !fin && m_ts >= m_rise && m_ts < m_fall;
    end
  endtask

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) cycle %0d: actual=%0d expected=%0d", rq, phase, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!p_rst) begin
      m_run = 0; m_en = 0; m_bit = 0; m_t = 0; m_ts = 0;
    end else begin
      evaluate();
      if (e_smp) m_bit = p_ttx;
      if (p_hs) begin
        m_run = 1; m_en = p_en; m_t = 0; m_ts = 0;
        m_dly = p_dly; m_rise = p_rise; m_fall = p_fall;
      end else if (m_run) begin
        m_t++;
        if (m_ts < 1023) m_ts++;
      end
    end
    evaluate();
    if (p_rst === 1'b1 && !finished) begin
      chk("R8 req", req_o, e_req);
      chk("R3/R6 win", win_o, e_win);
      chk("R2 smp", smp_o, e_smp);
      chk("R4 idx", idx_o, e_idx);
      chk("R5 bit", bit_o, m_bit);
    end
  end

  int lfsr = 32'h1ACE5;
  always @(negedge clk) begin
    #2;
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    ttx_i = lfsr[5];
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > WD_LIMIT && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WD_LIMIT);
      summary();
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sync(bit en, int dly, int rise, int fall);
    @(negedge clk); #1;
    hsync_i = 1; ttx_en_i = en; dly_i = 4'(dly);
    req_rise_i = 10'(rise); req_fall_i = 10'(fall);
    @(negedge clk); #1;
    hsync_i = 0;
  endtask

  initial begin
    idle(3); #1 rst_n = 1;
    phase = "R1 idle"; idle(40);
    phase = "R10 settings change mid-line";
    sync(1, 0, 250, 700);
    idle(100); #1; dly_i = 4'd9; req_rise_i = 10'd5; req_fall_i = 10'd20; ttx_en_i = 0;
    idle(1750);
    phase = "R2/R3 max delay, long request";
    sync(1, 15, 10, 1023); idle(1800);
    phase = "R7 disabled line";
    sync(0, 3, 0, 1023); idle(1800);
    phase = "R9 abort mid-line";
    sync(1, 5, 260, 900); idle(800);
    sync(1, 2, 300, 400); idle(1800);
    phase = "R6 after line end"; idle(50);
    finished = 1;
    summary();
  end
endmodule